// File: doc/BRIEF.md
# Synchronous Burst Read Output Controller

This block is the memory-side sequencer for a clocked burst read. The burst clock arrives as a plain input. The block samples it with the single system clock and turns each active transition of it into a one-cycle enable. A configuration bit chooses whether the rising or the falling transition is the active one. A falling latch-enable arms the sequencer, and the next active edge starts the burst. The block then counts a programmable initial latency and presents one array word per data period. A data period lasts one or two active edges. After each word it pulses an advance strobe to an external address generator.

The block drives a WAIT indication, and its polarity can be configured. WAIT covers the latency, any inserted wait state and the idle tail after a finite burst. Output enable being inactive, or valid data on the output, releases it. In continuous mode the controller inserts one wait state the first time the burst crosses a 16-word boundary, unless the burst started on a 4-word page boundary. A request that does not target the array is not served: the controller raises a refuse flag and never presents data for it. A new latch-enable fall aborts any burst in progress and starts over.

Top module: `burst_read_ctrl`

## Requirements
- R1: A burst starts on the first active burst-clock edge seen after the system clock samples latch enable going from 1 to 0. `cfg_fall_edge`=0 makes 0-to-1 transitions of `bclk` active, and `cfg_fall_edge`=1 makes 1-to-0 transitions active.
- R2: `cfg_lat_code` gives the latency L in active edges. Codes 2 to 5 are used as given, codes 0 and 1 act as 2, and codes 6 and 7 act as 5. The first word becomes valid on the L-th active edge after the start edge, and `dout_valid` stays low before that.
- R3: Word d of a burst is the `arr_data` value present after d pulses of `adv`. It stays on `dout` with `dout_valid` high for one active edge period when `cfg_hold2`=0 and for two when it is 1. `adv` pulses for exactly one system clock after each word is captured, and only then.
- R4: `cfg_len_code` 0, 1 and 2 give finite bursts of 4, 8 and 16 words. After the last word, `dout_valid` drops and WAIT stays asserted until the next latch-enable fall. Code 3 selects continuous mode.
- R5: WAIT is asserted during the latency, during an inserted wait state and after a finite burst ends. It is released while `dout_valid` is high, while `oe_n` is 1, in the idle state and after a refusal.
- R6: With `cfg_wait_hi`=1 the asserted level of `wait_o` is 1. With `cfg_wait_hi`=0 it is 0. The released level is the opposite.
- R7: In continuous mode, when the start address has `start_low[1:0]`≠0, the first word that would cross a 16-word boundary is delayed by one data period. During that period `dout_valid` is 0 and WAIT is asserted. Later crossings insert no wait state, and no wait state is ever inserted when `start_low[1:0]`=0.
- R8: When `array_req` is 0 at the start edge, `refuse` rises and stays high until the next latch-enable fall, with no data and no `adv` pulse.
- R9: A latch-enable fall during a burst drops `dout_valid` on the next system clock and restarts the sequence, including the latency count, from the new start address.
- R10: After reset, `dout_valid`, `refuse` and `adv` are 0 and `wait_o` sits at its released level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Burst clock, sampled by `clk` |
| le_n | input | 1 | Latch enable, active low |
| oe_n | input | 1 | Output enable, active low |
| start_low | input | 4 | Low four bits of the burst start address |
| array_req | input | 1 | 1 = array read, 0 = status/identification read |
| cfg_fall_edge | input | 1 | Active burst-clock edge select |
| cfg_lat_code | input | 3 | Initial latency code |
| cfg_hold2 | input | 1 | Hold each word for two active edges |
| cfg_len_code | input | 2 | Burst length code |
| cfg_wait_hi | input | 1 | WAIT polarity (1 = active high) |
| arr_data | input | DATA_W | Word at the generator's current address |
| adv | output | 1 | Advance strobe to the address generator |
| dout | output | DATA_W | Output word |
| dout_valid | output | 1 | Output word valid |
| wait_o | output | 1 | WAIT indication |
| refuse | output | 1 | Burst request rejected |

## Verification
The assertions rely on two properties of the inputs. A rising active edge of `bclk` needs two transitions, so no two edges of the same sense are closer than two system clocks. Configuration inputs and `array_req` are also assumed to stay unchanged while a burst runs. The stimulus runs the burst clock at a fixed six-clock period. It changes the configuration only between bursts. It lowers latch enable only in a cycle where no active edge follows directly, so a start can never coincide with the latch-enable fall.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int BND_W  = 4;
  localparam int PAGE_W = 2;
  localparam int LAT_W  = 3;
  localparam int CNT_W  = BND_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_LAT, ST_DATA, ST_WST, ST_DONE, ST_REFUSED
  } brd_state_e;

  function automatic logic [LAT_W-1:0] lat_clamp(input logic [LAT_W-1:0] code);
    if (code < LAT_W'(2)) return LAT_W'(2);
    if (code > LAT_W'(5)) return LAT_W'(5);
    return code;
  endfunction

  function automatic logic [CNT_W-1:0] len_words(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(4);
      2'd1:    return CNT_W'(8);
      2'd2:    return CNT_W'(16);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/brd_edge_qual.sv
module brd_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic le_n,
  input  logic fall_sel,
  output logic tick,
  output logic le_fall
);
  logic bclk_q, le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      le_q   <= 1'b1;
    end else begin
      bclk_q <= bclk;
      le_q   <= le_n;
    end
  end

  always_comb begin
    tick    = fall_sel ? (bclk_q & ~bclk) : (~bclk_q & bclk);
    le_fall = le_q & ~le_n;
  end
endmodule

// File: rtl/brd_seq.sv
module brd_seq
  import brd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              le_fall,
  input  logic              array_req,
  input  logic [BND_W-1:0]  start_low,
  input  logic [LAT_W-1:0]  cfg_lat_code,
  input  logic              cfg_hold2,
  input  logic [1:0]        cfg_len_code,
  input  logic [DATA_W-1:0] arr_data,
  output brd_state_e        st,
  output logic              adv,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              refuse
);
  brd_state_e        st_n;
  logic [LAT_W-1:0]  cnt, cnt_n;
  logic [BND_W-1:0]  pos, pos_n;
  logic [CNT_W-1:0]  beats, beats_n, words;
  logic              phase, phase_n;
  logic              need_ws, need_ws_n;
  logic [DATA_W-1:0] dout_n;
  logic              valid_n, refuse_n, take, cont;

  always_comb begin
    words     = len_words(cfg_len_code);
    cont      = (cfg_len_code == 2'd3);
    st_n      = st;
    cnt_n     = cnt;
    pos_n     = pos;
    beats_n   = beats;
    phase_n   = phase;
    need_ws_n = need_ws;
    dout_n    = dout;
    valid_n   = dout_valid;
    refuse_n  = refuse;
    take      = 1'b0;
    if (le_fall) begin
      st_n     = ST_ARMED;
      valid_n  = 1'b0;
      refuse_n = 1'b0;
    end else if (tick) begin
      case (st)
        ST_ARMED: begin
          if (array_req) begin
            st_n      = ST_LAT;
            cnt_n     = lat_clamp(cfg_lat_code) - LAT_W'(1);
            pos_n     = start_low;
            beats_n   = '0;
            phase_n   = 1'b0;
            need_ws_n = cont && (start_low[PAGE_W-1:0] != '0);
          end else begin
            st_n     = ST_REFUSED;
            refuse_n = 1'b1;
          end
        end
        ST_LAT: begin
          if (cnt == '0) take = 1'b1;
          else           cnt_n = cnt - LAT_W'(1);
        end
        ST_DATA: begin
          if (cfg_hold2 && !phase) begin
            phase_n = 1'b1;
          end else if (!cont && beats == words) begin
            st_n    = ST_DONE;
            valid_n = 1'b0;
          end else if (need_ws && pos == '0) begin
            st_n      = ST_WST;
            valid_n   = 1'b0;
            need_ws_n = 1'b0;
            phase_n   = 1'b0;
          end else begin
            take = 1'b1;
          end
        end
        ST_WST: begin
          if (cfg_hold2 && !phase) phase_n = 1'b1;
          else                     take    = 1'b1;
        end
        default: ;
      endcase
    end
    if (take) begin
      st_n    = ST_DATA;
      dout_n  = arr_data;
      valid_n = 1'b1;
      pos_n   = pos + BND_W'(1);
      beats_n = beats + CNT_W'(1);
      phase_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      pos        <= '0;
      beats      <= '0;
      phase      <= 1'b0;
      need_ws    <= 1'b0;
      dout       <= '0;
      dout_valid <= 1'b0;
      refuse     <= 1'b0;
      adv        <= 1'b0;
    end else begin
      st         <= st_n;
      cnt        <= cnt_n;
      pos        <= pos_n;
      beats      <= beats_n;
      phase      <= phase_n;
      need_ws    <= need_ws_n;
      dout       <= dout_n;
      dout_valid <= valid_n;
      refuse     <= refuse_n;
      adv        <= take;
    end
  end
endmodule

// File: rtl/brd_wait_gen.sv
module brd_wait_gen
  import brd_pkg::*;
(
  input  brd_state_e st,
  input  logic       oe_n,
  input  logic       active_hi,
  output logic       wait_o
);
  logic stall;

  always_comb begin
    stall  = (st == ST_LAT) || (st == ST_WST) || (st == ST_DONE);
    wait_o = (stall && !oe_n) ? active_hi : ~active_hi;
  end
endmodule

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl
  import brd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              le_n,
  input  logic              oe_n,
  input  logic [BND_W-1:0]  start_low,
  input  logic              array_req,
  input  logic              cfg_fall_edge,
  input  logic [LAT_W-1:0]  cfg_lat_code,
  input  logic              cfg_hold2,
  input  logic [1:0]        cfg_len_code,
  input  logic              cfg_wait_hi,
  input  logic [DATA_W-1:0] arr_data,
  output logic              adv,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              wait_o,
  output logic              refuse
);
  logic       rst_s0, rst_s1;
  logic       tick, le_fall;
  brd_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  brd_edge_qual i_edge (
    .clk      (clk),
    .rst_n    (rst_s1),
    .bclk     (bclk),
    .le_n     (le_n),
    .fall_sel (cfg_fall_edge),
    .tick     (tick),
    .le_fall  (le_fall)
  );

  brd_seq #(.DATA_W(DATA_W)) i_seq (
    .clk          (clk),
    .rst_n        (rst_s1),
    .tick         (tick),
    .le_fall      (le_fall),
    .array_req    (array_req),
    .start_low    (start_low),
    .cfg_lat_code (cfg_lat_code),
    .cfg_hold2    (cfg_hold2),
    .cfg_len_code (cfg_len_code),
    .arr_data     (arr_data),
    .st           (st),
    .adv          (adv),
    .dout         (dout),
    .dout_valid   (dout_valid),
    .refuse       (refuse)
  );

  brd_wait_gen i_wait (
    .st        (st),
    .oe_n      (oe_n),
    .active_hi (cfg_wait_hi),
    .wait_o    (wait_o)
  );
endmodule

// File: rtl/brd_checker.sv
module brd_checker (
  input logic clk,
  input logic rst_n,
  input logic le_n,
  input logic oe_n,
  input logic cfg_wait_hi,
  input logic adv,
  input logic dout_valid,
  input logic wait_o,
  input logic refuse
);
  // R3
  adv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !adv);
  // R3
  adv_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> dout_valid);
  // R8
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |-> (!dout_valid && !adv));
  // R5
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid || oe_n) |-> (wait_o == !cfg_wait_hi));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(le_n) |=> !dout_valid);
endmodule

bind burst_read_ctrl brd_checker i_brd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .le_n        (le_n),
  .oe_n        (oe_n),
  .cfg_wait_hi (cfg_wait_hi),
  .adv         (adv),
  .dout_valid  (dout_valid),
  .wait_o      (wait_o),
  .refuse      (refuse)
);

// File: tb/test_burst_read_ctrl.sv
module test_burst_read_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, bclk, le_n, oe_n, array_req;
  logic [3:0]  start_low;
  logic        cfg_fall_edge, cfg_hold2, cfg_wait_hi;
  logic [2:0]  cfg_lat_code;
  logic [1:0]  cfg_len_code;
  logic [15:0] arr_data;
  logic        adv, dout_valid, wait_o, refuse;
  logic [15:0] dout;

  burst_read_ctrl i_burst_read_ctrl (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .le_n(le_n), .oe_n(oe_n),
    .start_low(start_low), .array_req(array_req),
    .cfg_fall_edge(cfg_fall_edge), .cfg_lat_code(cfg_lat_code),
    .cfg_hold2(cfg_hold2), .cfg_len_code(cfg_len_code),
    .cfg_wait_hi(cfg_wait_hi), .arr_data(arr_data), .adv(adv),
    .dout(dout), .dout_valid(dout_valid), .wait_o(wait_o), .refuse(refuse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0, n_err = 0;
  int    bph = 0, k = -1, cur_s = 0, lat = 2, hold = 1, nwords = 4;
  int    gen_addr = 0, adv_cnt = 0, le_hold = 0, kmax = 0;
  bit    act = 0, pend_tick = 0, want_le = 0, refused_exp = 0, prev_b = 0;
  string xtag = "";

  function automatic logic [15:0] word_of(int a);
    return 16'((a * 40503) ^ 32'h1234);
  endfunction

  function automatic int lat_of(int c);
    return (c < 2) ? 2 : (c > 5) ? 5 : c;
  endfunction

  // 0 latency, 1 data, 2 inserted wait state, 3 finished
  function automatic int kind_at(int kk, int l, int h, int n, int s);
    int d, b;
    if (kk < l) return 0;
    d = (kk - l) / h;
    if (n != 0) return (d < n) ? 1 : 3;
    b = 16 - (s % 16);
    if ((s % 4) != 0 && d == b) return 2;
    return 1;
  endfunction

  function automatic int addr_at(int kk, int l, int h, int n, int s);
    int d, b;
    d = (kk - l) / h;
    b = 16 - (s % 16);
    if (n == 0 && (s % 4) != 0 && d > b) return s + d - 1;
    return s + d;
  endfunction

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (k=%0d s=%0d)", req, actv, expv, k, cur_s);
    end
  endtask

  task automatic check_tick();
    int    kd, ev, ew;
    string tg;
    if (refused_exp) begin
      chk(refuse == 1'b1, {"R8 ", xtag}, int'(refuse), 1);
      chk(dout_valid == 1'b0, {"R8 ", xtag}, int'(dout_valid), 0);
      chk(adv_cnt == 0, "R8 adv", adv_cnt, 0);
      chk(wait_o == !cfg_wait_hi, "R5 R8 wait", int'(wait_o), int'(!cfg_wait_hi));
      return;
    end
    kd = kind_at(k, lat, hold, nwords, cur_s);
    tg = (kd == 0) ? "R2" : (kd == 1) ? "R3" : (kd == 2) ? "R7" : "R4";
    ev = (kd == 1);
    chk(int'(dout_valid) == ev, {tg, " valid ", xtag}, int'(dout_valid), ev);
    if (ev == 1)
      chk(dout == word_of(addr_at(k, lat, hold, nwords, cur_s)), {"R3 data ", xtag},
          int'(dout), int'(word_of(addr_at(k, lat, hold, nwords, cur_s))));
    ew = (kd != 1 && !oe_n) ? int'(cfg_wait_hi) : int'(!cfg_wait_hi);
    chk(int'(wait_o) == ew, {(kd == 2) ? "R7" : "R5 R6", " wait ", xtag}, int'(wait_o), ew);
    chk(refuse == 1'b0, "R8 no refuse", int'(refuse), 0);
  endtask

  task automatic step();
    bit nb;
    @(negedge clk);
    if (pend_tick && act && rst_n) begin
      k++;
      if (k >= 0) check_tick();
    end
    if (adv === 1'b1) begin
      gen_addr++;
      adv_cnt++;
    end
    bph    = (bph + 1) % 6;
    nb     = (bph < 3);
    prev_b = bclk;
    pend_tick = (nb != bclk) && (nb == !cfg_fall_edge);
    bclk   = nb;
    if (want_le && !pend_tick && le_n) begin
      le_n = 1'b0; le_hold = 2; want_le = 0; act = 1; k = -1;
      gen_addr = cur_s; adv_cnt = 0;
    end else if (le_hold > 0) begin
      le_hold--;
      if (le_hold == 0) le_n = 1'b1;
    end
    oe_n      = ($urandom % 5 == 0);
    start_low = 4'(cur_s);
    arr_data  = word_of(gen_addr);
  endtask

  task automatic run_burst(input int s, input int lc, input int h2, input int len,
                           input bit f, input bit p, input bit arr,
                           input int abort_k, input int s2, input string tg);
    int ab;
    ab = abort_k;
    cfg_fall_edge = f;
    pend_tick     = (bclk != prev_b) && (bclk == !f);
    cfg_lat_code  = 3'(lc);
    cfg_hold2     = h2[0];
    cfg_len_code  = 2'(len);
    cfg_wait_hi   = p;
    array_req     = arr;
    lat    = lat_of(lc);
    hold   = h2 ? 2 : 1;
    nwords = (len == 3) ? 0 : (4 << len);
    kmax   = lat + hold * ((nwords == 0) ? 21 : nwords + 2);
    refused_exp = !arr;
    xtag   = tg;
    cur_s  = s;
    want_le = 1;
    while (want_le || k < kmax) begin
      step();
      if (ab >= 0 && act && k == ab) begin
        cur_s = s2; want_le = 1; ab = -1; xtag = {tg, " R9"};
      end
    end
    act = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(7);
    rst_n = 1'b0; bclk = 1'b0; le_n = 1'b1; oe_n = 1'b0; array_req = 1'b1;
    start_low = '0; cfg_fall_edge = 1'b0; cfg_hold2 = 1'b0; cfg_wait_hi = 1'b1;
    cfg_lat_code = 3'd2; cfg_len_code = 2'd0; arr_data = '0;
    repeat (4) step();
    // R10 reset state
    chk(dout_valid == 1'b0, "R10 valid", int'(dout_valid), 0);
    chk(refuse == 1'b0, "R10 refuse", int'(refuse), 0);
    chk(adv == 1'b0, "R10 adv", int'(adv), 0);
    chk(wait_o == 1'b0 || oe_n, "R10 wait", int'(wait_o), 0);
    rst_n = 1'b1;
    repeat (6) step();
    chk(dout_valid == 1'b0 && refuse == 1'b0, "R10 idle after release",
        int'({dout_valid, refuse}), 0);
    chk(wait_o == !cfg_wait_hi, "R10 R6 idle wait", int'(wait_o), int'(!cfg_wait_hi));

    // directed corners
    run_burst(0,  2, 0, 0, 0, 1, 1, -1, 0,  "R1 len4");
    run_burst(5,  3, 1, 1, 0, 0, 1, -1, 0,  "R4 len8 hold2");
    run_burst(9,  0, 0, 2, 1, 1, 1, -1, 0,  "R1 fall len16 clamp-low");
    run_burst(3,  7, 0, 3, 0, 1, 1, -1, 0,  "R7 cont clamp-high");
    run_burst(13, 4, 1, 3, 1, 0, 1, -1, 0,  "R7 cont hold2");
    run_burst(4,  2, 0, 3, 0, 1, 1, -1, 0,  "R7 page-aligned");
    run_burst(15, 5, 0, 3, 0, 1, 1, -1, 0,  "R7 end-of-page");
    run_burst(0,  3, 0, 3, 1, 0, 1, -1, 0,  "R7 aligned16");
    run_burst(6,  2, 0, 1, 0, 1, 0, -1, 0,  "R8 refused");
    run_burst(2,  5, 0, 1, 0, 1, 1,  7, 21, "R9 abort");

    for (int i = 0; i < 30; i++) begin
      int s, ab;
      s  = $urandom % 512;
      ab = ($urandom % 4 == 0) ? int'($urandom % 8) : -1;
      run_burst(s, $urandom % 8, $urandom % 2, $urandom % 4, 1'($urandom % 2),
                1'($urandom % 2), ($urandom % 6 != 0), ab, $urandom % 512, "random");
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule